// File: doc/BRIEF.md
# Candidate Spike Transfer Arbiter

This block sits between sixteen spike-detection processing elements and a downstream processor. A processing element that is holding a candidate spike raises its request line. The arbiter grants one requester at a time in round-robin order. It then copies that requester's candidate into one slot of a shared buffer memory through a plain write port. The copy is one header word followed by the sample words, which the arbiter fetches from the granted element by presenting a sample index.

When the last word of a candidate has been written, the arbiter sends the processor a one-cycle trigger pulse together with the number of the slot it filled, so that the processor can run its energy check on that slot. The processor returns the slot by presenting an acknowledge with the slot number. The buffer has four slots. While every slot is occupied, no new grant is issued, and the requesters wait.

Top module: `spike_cand_arbiter`

## Requirements
- R1: After reset, grantVec is all zero, bufWrEn is 0, trigPulse is 0, the round-robin pointer is at requester 0 and all four slots are free.
- R2: grantVec is either zero or one-hot. A grant stays unchanged for the 33 cycles of its transfer. Changes on reqVec during a transfer have no effect on the grant or on the written data.
- R3: The next grant goes to the first requesting index found by scanning upward, with wrap-around, from the index one above the last granted requester.
- R4: The first word written for a candidate (word 0) is the 128-channel index: bits [6:3] hold the requester number, bits [2:0] hold that requester's local channel from peChan, and bit 7 is zero.
- R5: Words 1 to 32 are the granted requester's samples 0 to 31, in that order. Sample k is requested by driving sampleIdx = k in the cycle in which word k+1 is written.
- R6: Each word is written with bufWrEn high at bufWrAddr = slot*64 + word, so the slot occupies bits [7:6] and the word number occupies bits [5:0]. One word is written per cycle on consecutive cycles, and the grant becomes visible in the same cycle as word 0.
- R7: trigPulse is high for exactly one cycle, in the cycle after word 32 is written. trigSlot carries the slot that was filled, and grantVec is zero in that cycle.
- R8: A new candidate takes the lowest-numbered free slot. While all four slots are occupied, no grant is issued and nothing is written.
- R9: ackValid with ackSlot frees that slot, and the freed slot can be allocated in the same cycle in which the acknowledge is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqVec | input | 16 | Candidate request, one bit per processing element |
| peChan | input | 48 | Local channel (3 bits) of each element's candidate, element i at bits [3i+2:3i] |
| peSample | input | 128 | Sample word from each element at the index sampleIdx, element i at bits [8i+7:8i] |
| ackValid | input | 1 | Processor returns a slot |
| ackSlot | input | 2 | Slot being returned |
| grantVec | output | 16 | One-hot grant, held during the transfer |
| sampleIdx | output | 5 | Sample index requested from the granted element |
| bufWrEn | output | 1 | Buffer write strobe |
| bufWrAddr | output | 8 | Buffer write address {slot, word} |
| bufWrData | output | 8 | Buffer write data |
| trigPulse | output | 1 | One-cycle trigger to the processor |
| trigSlot | output | 2 | Slot filled by the finished transfer |

## Verification
Single requests at both ends of the index range show that grants go to the right requester and that the header encodes the requester number. Pairs of requests that lie on either side of the round-robin pointer separate true rotation from fixed priority, including wrap-around. A full sixteen-way request checks a complete rotation that starts part-way round. In a run without acknowledges, four slots fill and a fifth requester is held off until one middle slot is returned, which tells lowest-free allocation apart from sequential allocation. Inverting the requests in the middle of a transfer shows that the grant and the copied data are unaffected.

// File: rtl/spike_cand_arbiter_pkg.sv
package spike_cand_arbiter_pkg;
  localparam int NUM_REQ   = 16;
  localparam int SAMPLES   = 32;
  localparam int WORD_W    = 8;
  localparam int PE_CH_W   = 3;
  localparam int NUM_SLOTS = 4;
  localparam int REQ_W     = $clog2(NUM_REQ);
  localparam int SLOT_W    = $clog2(NUM_SLOTS);
  localparam int WORDS     = SAMPLES + 1;
  localparam int WCNT_W    = $clog2(WORDS);
  localparam int SIDX_W    = $clog2(SAMPLES);
  localparam int ADDR_W    = SLOT_W + WCNT_W;

  typedef struct packed {
    logic              wrEn;
    logic [WCNT_W-1:0] wordIdx;
    logic [REQ_W-1:0]  owner;
    logic [SLOT_W-1:0] slot;
  } dpCtl_t;
endpackage

// File: rtl/spike_cand_arb_ctrl.sv
module spike_cand_arb_ctrl
  import spike_cand_arbiter_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_REQ-1:0]   reqVec,
  input  logic                 ackValid,
  input  logic [SLOT_W-1:0]    ackSlot,
  output logic [NUM_REQ-1:0]   grantVec,
  output logic                 trigPulse,
  output logic [SLOT_W-1:0]    trigSlot,
  output dpCtl_t               dpCtl
);
  typedef enum logic {S_IDLE, S_XFER} state_t;

  state_t              state;
  logic [REQ_W-1:0]    rrPtr;
  logic [REQ_W-1:0]    owner;
  logic [SLOT_W-1:0]   slot;
  logic [WCNT_W-1:0]   wordCnt;
  logic [NUM_SLOTS-1:0] slotBusy;

  logic [NUM_SLOTS-1:0] ackMask;
  logic [NUM_SLOTS-1:0] busyEff;
  logic [NUM_SLOTS-1:0] allocMask;
  logic [REQ_W-1:0]     winIdx;
  logic [REQ_W-1:0]     cand;
  logic                 found;
  logic [SLOT_W-1:0]    freeSlot;
  logic                 anyFree;
  logic                 start;
  logic                 lastWord;

  always_comb begin
    ackMask = '0;
    if (ackValid) ackMask[ackSlot] = 1'b1;
    busyEff = slotBusy & ~ackMask;
  end

  // round-robin scan starting at the pointer
  always_comb begin
    found  = 1'b0;
    winIdx = '0;
    cand   = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      cand = rrPtr + REQ_W'(i);
      if (!found && reqVec[cand]) begin
        found  = 1'b1;
        winIdx = cand;
      end
    end
  end

  // lowest free slot
  always_comb begin
    freeSlot = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--)
      if (!busyEff[s]) freeSlot = SLOT_W'(s);
    anyFree = ~&busyEff;
  end

  assign start    = (state == S_IDLE) && found && anyFree;
  assign lastWord = (state == S_XFER) && (wordCnt == WCNT_W'(WORDS - 1));

  always_comb begin
    allocMask = '0;
    if (start) allocMask[freeSlot] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      rrPtr     <= '0;
      owner     <= '0;
      slot      <= '0;
      wordCnt   <= '0;
      slotBusy  <= '0;
      trigPulse <= 1'b0;
      trigSlot  <= '0;
    end else begin
      trigPulse <= 1'b0;
      slotBusy  <= busyEff | allocMask;
      case (state)
        S_IDLE: if (start) begin
          state   <= S_XFER;
          owner   <= winIdx;
          slot    <= freeSlot;
          wordCnt <= '0;
        end
        S_XFER: begin
          wordCnt <= wordCnt + 1'b1;
          if (lastWord) begin
            state     <= S_IDLE;
            rrPtr     <= owner + 1'b1;
            trigPulse <= 1'b1;
            trigSlot  <= slot;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    grantVec = '0;
    if (state == S_XFER) grantVec[owner] = 1'b1;
    dpCtl.wrEn    = (state == S_XFER);
    dpCtl.wordIdx = wordCnt;
    dpCtl.owner   = owner;
    dpCtl.slot    = slot;
  end

  // R2: at most one grant at any time
  a_r2_grant_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec));

  // R2: grant held until the transfer ends
  a_r2_grant_held: assert property (@(posedge clk) disable iff (!rstN)
    (grantVec != '0 && !lastWord) |=> $stable(grantVec));

  // R7: trigger follows the last word and lasts one cycle
  a_r7_trig_after_last: assert property (@(posedge clk) disable iff (!rstN)
    lastWord |=> (trigPulse && grantVec == '0));
  a_r7_trig_single: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |=> !trigPulse);

  // R8: no grant while every slot is occupied and none is returned
  a_r8_no_grant_full: assert property (@(posedge clk) disable iff (!rstN)
    (grantVec == '0 && &slotBusy && !ackValid) |=> grantVec == '0);
endmodule

// File: rtl/spike_cand_arb_datapath.sv
module spike_cand_arb_datapath
  import spike_cand_arbiter_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  dpCtl_t                       dpCtl,
  input  logic [NUM_REQ*PE_CH_W-1:0]   peChan,
  input  logic [NUM_REQ*WORD_W-1:0]    peSample,
  output logic [SIDX_W-1:0]            sampleIdx,
  output logic                         bufWrEn,
  output logic [ADDR_W-1:0]            bufWrAddr,
  output logic [WORD_W-1:0]            bufWrData
);
  logic [PE_CH_W-1:0] chanArr [NUM_REQ];
  logic [WORD_W-1:0]  sampArr [NUM_REQ];

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_unpack
    assign chanArr[g] = peChan[g*PE_CH_W +: PE_CH_W];
    assign sampArr[g] = peSample[g*WORD_W +: WORD_W];
  end

  logic              isHdr;
  logic [WORD_W-1:0] hdrWord;

  assign isHdr     = (dpCtl.wordIdx == '0);
  assign hdrWord   = WORD_W'({dpCtl.owner, chanArr[dpCtl.owner]});
  assign sampleIdx = isHdr ? '0 : SIDX_W'(dpCtl.wordIdx - 1'b1);
  assign bufWrEn   = dpCtl.wrEn;
  assign bufWrAddr = {dpCtl.slot, dpCtl.wordIdx};
  assign bufWrData = isHdr ? hdrWord : sampArr[dpCtl.owner];

  // R6: consecutive writes of one transfer step the address by one
  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    (bufWrEn && $past(bufWrEn) && !isHdr) |-> bufWrAddr == $past(bufWrAddr) + 1'b1);

  // R4: the header has its unused top bits clear
  a_r4_hdr_top_clear: assert property (@(posedge clk) disable iff (!rstN)
    (bufWrEn && isHdr) |-> (bufWrData >> (REQ_W + PE_CH_W)) == '0);
endmodule

// File: rtl/spike_cand_arbiter.sv
module spike_cand_arbiter
  import spike_cand_arbiter_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_REQ-1:0]          reqVec,
  input  logic [NUM_REQ*PE_CH_W-1:0]  peChan,
  input  logic [NUM_REQ*WORD_W-1:0]   peSample,
  input  logic                        ackValid,
  input  logic [SLOT_W-1:0]           ackSlot,
  output logic [NUM_REQ-1:0]          grantVec,
  output logic [SIDX_W-1:0]           sampleIdx,
  output logic                        bufWrEn,
  output logic [ADDR_W-1:0]           bufWrAddr,
  output logic [WORD_W-1:0]           bufWrData,
  output logic                        trigPulse,
  output logic [SLOT_W-1:0]           trigSlot
);
  dpCtl_t dpCtl;

  spike_cand_arb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .ackValid(ackValid),
    .ackSlot(ackSlot), .grantVec(grantVec), .trigPulse(trigPulse),
    .trigSlot(trigSlot), .dpCtl(dpCtl)
  );

  spike_cand_arb_datapath u_dp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .peChan(peChan),
    .peSample(peSample), .sampleIdx(sampleIdx), .bufWrEn(bufWrEn),
    .bufWrAddr(bufWrAddr), .bufWrData(bufWrData)
  );
endmodule

// File: tb/spike_cand_arbiter_test.sv
`timescale 1ns/1ps
module spike_cand_arbiter_test;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [15:0]  reqVec = '0;
  logic [47:0]  peChan;
  logic [127:0] peSample;
  logic         ackValid = 1'b0;
  logic [1:0]   ackSlot = '0;
  logic [15:0]  grantVec;
  logic [4:0]   sampleIdx;
  logic         bufWrEn;
  logic [7:0]   bufWrAddr;
  logic [7:0]   bufWrData;
  logic         trigPulse;
  logic [1:0]   trigSlot;

  int nChecks = 0;
  int nFails = 0;
  int mPtr = 0;
  logic [3:0] mBusy = '0;
  bit autoAck = 1'b1;
  bit done = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [7:0] expSample(int pe, int s);
    return 8'(pe * 37 + s * 11 + 3);
  endfunction

  for (genvar g = 0; g < 16; g++) begin : g_pe
    assign peChan[g*3 +: 3]   = 3'((g * 5) % 8);
    assign peSample[g*8 +: 8] = expSample(g, int'(sampleIdx));
  end

  spike_cand_arbiter uut (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .peChan(peChan),
    .peSample(peSample), .ackValid(ackValid), .ackSlot(ackSlot),
    .grantVec(grantVec), .sampleIdx(sampleIdx), .bufWrEn(bufWrEn),
    .bufWrAddr(bufWrAddr), .bufWrData(bufWrData), .trigPulse(trigPulse),
    .trigSlot(trigSlot)
  );

  // request mask, expected first winner
  localparam logic [19:0] VEC [5] = '{
    {16'h0001, 4'd0}, {16'h8000, 4'd15}, {16'h0011, 4'd0},
    {16'h0024, 4'd5}, {16'hFFFF, 4'd3}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  task automatic doXfer(output int gotIdx);
    int expIdx;
    int expSlot;
    int waitCnt;
    logic [15:0] saved;
    waitCnt = 0;
    while (grantVec == '0 && waitCnt < 200) begin
      @(negedge clk);
      waitCnt++;
    end
    expIdx = -1;
    for (int i = 0; i < 16; i++)
      if (expIdx < 0 && reqVec[(mPtr + i) % 16]) expIdx = (mPtr + i) % 16;
    expSlot = -1;
    for (int s = 0; s < 4; s++)
      if (expSlot < 0 && !mBusy[s]) expSlot = s;
    gotIdx = -1;
    for (int i = 0; i < 16; i++) if (grantVec[i]) gotIdx = i;
    chk("R3 grant", 32'(grantVec), 32'(16'd1 << expIdx));
    mBusy[expSlot] = 1'b1;
    reqVec[expIdx] = 1'b0;
    saved = '0;
    for (int w = 0; w < 33; w++) begin
      chk("R6 write enable", 32'(bufWrEn), 32'd1);
      chk("R6 address", 32'(bufWrAddr), 32'(expSlot * 64 + w));
      chk("R2 grant held", 32'(grantVec), 32'(16'd1 << expIdx));
      if (w == 0)
        chk("R4 header", 32'(bufWrData), 32'(expIdx * 8 + (expIdx * 5) % 8));
      else
        chk("R5 sample", 32'(bufWrData), 32'(expSample(expIdx, w - 1)));
      if (w == 5) begin saved = reqVec; reqVec = ~saved; end
      if (w == 6) reqVec = saved;
      @(negedge clk);
    end
    chk("R7 trigger", 32'(trigPulse), 32'd1);
    chk("R7 trigger slot", 32'(trigSlot), 32'(expSlot));
    chk("R7 grant released", 32'(grantVec), 32'd0);
    mPtr = (expIdx + 1) % 16;
    if (autoAck) begin
      ackValid = 1'b1;
      ackSlot  = 2'(expSlot);
      mBusy[expSlot] = 1'b0;
    end
    @(negedge clk);
    ackValid = 1'b0;
    chk("R7 single pulse", 32'(trigPulse), 32'd0);
  endtask

  initial begin : watchdog
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int got;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 grant", 32'(grantVec), 32'd0);
    chk("R1 write", 32'(bufWrEn), 32'd0);
    chk("R1 trigger", 32'(trigPulse), 32'd0);

    foreach (VEC[v]) begin
      reqVec = reqVec | VEC[v][19:4];
      @(negedge clk);
      doXfer(got);
      chk("R3 first winner", 32'(got), 32'(VEC[v][3:0]));
      while (reqVec != '0) doXfer(got);
      repeat (3) @(negedge clk);
      chk("R2 idle no grant", 32'(grantVec), 32'd0);
    end

    // R8: fill every slot, fifth requester must wait
    autoAck = 1'b0;
    reqVec = 16'h00F8;
    @(negedge clk);
    for (int k = 0; k < 4; k++) doXfer(got);
    for (int k = 0; k < 20; k++) begin
      chk("R8 held off grant", 32'(grantVec), 32'd0);
      chk("R8 held off write", 32'(bufWrEn), 32'd0);
      @(negedge clk);
    end
    // R9: returning slot 2 admits the waiting requester into slot 2
    ackValid = 1'b1;
    ackSlot  = 2'd2;
    mBusy[2] = 1'b0;
    @(negedge clk);
    ackValid = 1'b0;
    chk("R9 freed slot granted", 32'(grantVec), 32'h0080);
    doXfer(got);
    chk("R9 requester", 32'(got), 32'd7);
    for (int s = 0; s < 4; s++) begin
      ackValid = 1'b1;
      ackSlot  = 2'(s);
      @(negedge clk);
    end
    ackValid = 1'b0;
    mBusy = '0;
    autoAck = 1'b1;
    // R9: slots reusable after return
    reqVec = 16'h0100;
    @(negedge clk);
    doXfer(got);
    chk("R9 reuse", 32'(got), 32'd8);

    done = 1'b1;
    summary();
  end
endmodule